// File: doc/BRIEF.md
# Bit-Serial Word Adder

This block adds two unsigned operands that arrive one bit per clock, least significant bit first. Each cycle that the valid strobe is high, a single full adder combines the two incoming operand bits with a one-bit stored carry. It emits one sum bit and keeps the new carry for the next bit. A start marker on the lowest bit of a word forces the carry-in to zero, so words can be streamed back to back with no reset and no idle cycle between them. The block spends latency to save area: an N-bit addition takes N valid cycles but needs only one full adder and one carry flop.

A bit counter finds the top bit of each word. On that bit the block flags the serial sum bit as the word's last and presents the word's carry-out beside it. An optional deserialiser, chosen by parameter, gathers the serial sum bits and presents the whole N-bit result with its carry-out as one parallel word. Gaps in the valid strobe can occur anywhere inside a word; the addition simply stalls through them.

Top module: `bit_serial_adder`

## Requirements
- R1: One cycle after a cycle with `in_valid` high, `out_sum` equals `in_a` XOR `in_b` XOR the carry-in used for that bit.
- R2: When `in_first` is high with `in_valid`, the carry-in for that bit is 0 and the bit counts as bit position 0 of a new word, even in the middle of a word.
- R3: The carry-out of each valid bit (the majority of `in_a`, `in_b` and the carry-in) is the carry-in of the next valid bit.
- R4: One cycle after the valid bit at position N-1, `out_last` is 1 and `out_carry` is bit N of the word's sum. `out_last` and `out_carry` are 0 on all other cycles.
- R5: One cycle after a cycle with `in_valid` low, `out_valid`, `out_sum`, `out_last` and `out_carry` are all 0.
- R6: A new word may start on the cycle right after the previous word's last bit, and its result is unaffected by the previous word.
- R7: A synchronous active-high `rst` clears the stored carry, the bit position, the serial outputs and the parallel outputs. A bit that arrives after reset without `in_first` is handled as position 0 with carry-in 0.
- R8: When the deserialiser is enabled, `word_valid` pulses one cycle after `out_last`. In that cycle `word_sum` bit i is the sum bit of position i and `word_carry` equals the word's carry-out, so {`word_carry`,`word_sum`} equals a+b.
- R9: Cycles with `in_valid` low inside a word do not change the word's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand bits are present this cycle |
| in_first | input | 1 | Marks the least significant bit of a word |
| in_a | input | 1 | Serial operand A bit |
| in_b | input | 1 | Serial operand B bit |
| out_valid | output | 1 | Serial sum bit is valid |
| out_sum | output | 1 | Serial sum bit |
| out_last | output | 1 | Sum bit is the word's top bit |
| out_carry | output | 1 | Word carry-out, valid with out_last |
| word_valid | output | 1 | Parallel result pulse |
| word_sum | output | N | Parallel sum word |
| word_carry | output | 1 | Parallel word carry-out |

## Verification
The assertions assume that a word which follows a finished word is always opened with `in_first`. Without the marker, the stored carry of the finished word would carry into the next word, and the model-free checks on the first sum bit and on carry ordering could not tell which word a bit belongs to. The stimulus always marks the first bit of a fresh word. It uses unmarked bits only right after reset, where R7 defines them, and it restarts words in the middle only with the marker raised. The assertions also assume that `in_a` and `in_b` are known whenever `in_valid` is high. The bench always drives defined values.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

  function automatic logic bsa_sum_bit(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  function automatic logic bsa_majority(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/bsa_carry_cell.sv
module bsa_carry_cell
  import bsa_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_first,
  input  logic in_a,
  input  logic in_b,
  output logic sum_bit,
  output logic bit_carry,
  output logic carry_q
);

  logic carry_in;

  assign carry_in  = in_first ? 1'b0 : carry_q;
  assign sum_bit   = bsa_sum_bit(in_a, in_b, carry_in);
  assign bit_carry = bsa_majority(in_a, in_b, carry_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q <= 1'b0;
    end else if (in_valid) begin
      carry_q <= bit_carry;
    end
  end

  // two ones always generate a carry for the next bit
  assert_gen_carry_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_a && in_b) |=> carry_q);

  // two zeros always kill the carry
  assert_kill_carry_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_a && !in_b) |=> !carry_q);

  // idle cycles keep the stored carry
  assert_carry_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(carry_q));

endmodule

// File: rtl/bsa_position.sv
module bsa_position #(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_first,
  output logic is_last
);

  localparam int PW = (N > 2) ? $clog2(N) : 1;
  localparam logic [PW-1:0] TOP = PW'(N - 1);

  logic [PW-1:0] pos_q;
  logic [PW-1:0] pos_cur;

  assign pos_cur = in_first ? '0 : pos_q;
  assign is_last = (pos_cur == TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
    end else if (in_valid) begin
      pos_q <= is_last ? '0 : pos_cur + PW'(1);
    end
  end

  assert_pos_range_R4: assert property (@(posedge clk) disable iff (rst)
    pos_q <= TOP);

  assert_first_restart_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_first) |=> (pos_q == PW'(1 % N)));

endmodule

// File: rtl/bsa_deser.sv
module bsa_deser #(
  parameter int N      = 8,
  parameter bit ENABLE = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         s_valid,
  input  logic         s_sum,
  input  logic         s_last,
  input  logic         s_carry,
  output logic         word_valid,
  output logic [N-1:0] word_sum,
  output logic         word_carry
);

  generate
    if (ENABLE) begin : g_deser
      logic [N-1:0] shift_q;
      logic [N-1:0] shift_next;
      logic         wv_q;
      logic [N-1:0] ws_q;
      logic         wc_q;
      logic         word_done;

      assign word_done = s_valid && s_last;

      if (N > 1) begin : g_wide
        assign shift_next = {s_sum, shift_q[N-1:1]};
      end else begin : g_narrow
        assign shift_next = s_sum;
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          shift_q <= '0;
          wv_q    <= 1'b0;
          ws_q    <= '0;
          wc_q    <= 1'b0;
        end else begin
          wv_q <= word_done;
          if (s_valid) begin
            shift_q <= shift_next;
          end
          if (word_done) begin
            ws_q <= shift_next;
            wc_q <= s_carry;
          end
        end
      end

      assign word_valid = wv_q;
      assign word_sum   = ws_q;
      assign word_carry = wc_q;

      assert_word_after_last_R8: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> $past(s_valid && s_last));

      assert_word_msb_R8: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> (word_sum[N-1] == $past(s_sum)));
    end else begin : g_none
      assign word_valid = 1'b0;
      assign word_sum   = '0;
      assign word_carry = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/bit_serial_adder.sv
module bit_serial_adder #(
  parameter int N           = 8,
  parameter bit HAS_WORD_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic         in_first,
  input  logic         in_a,
  input  logic         in_b,
  output logic         out_valid,
  output logic         out_sum,
  output logic         out_last,
  output logic         out_carry,
  output logic         word_valid,
  output logic [N-1:0] word_sum,
  output logic         word_carry
);

  logic sum_bit;
  logic bit_carry;
  logic carry_q;
  logic is_last;

  logic ov_q;
  logic os_q;
  logic ol_q;
  logic oc_q;

  bsa_carry_cell u_cell (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_first  (in_first),
    .in_a      (in_a),
    .in_b      (in_b),
    .sum_bit   (sum_bit),
    .bit_carry (bit_carry),
    .carry_q   (carry_q)
  );

  bsa_position #(.N(N)) u_pos (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_first (in_first),
    .is_last  (is_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ov_q <= 1'b0;
      os_q <= 1'b0;
      ol_q <= 1'b0;
      oc_q <= 1'b0;
    end else begin
      ov_q <= in_valid;
      os_q <= in_valid & sum_bit;
      ol_q <= in_valid & is_last;
      oc_q <= in_valid & is_last & bit_carry;
    end
  end

  assign out_valid = ov_q;
  assign out_sum   = os_q;
  assign out_last  = ol_q;
  assign out_carry = oc_q;

  bsa_deser #(.N(N), .ENABLE(HAS_WORD_OUT)) u_deser (
    .clk        (clk),
    .rst        (rst),
    .s_valid    (ov_q),
    .s_sum      (os_q),
    .s_last     (ol_q),
    .s_carry    (oc_q),
    .word_valid (word_valid),
    .word_sum   (word_sum),
    .word_carry (word_carry)
  );

  assert_first_sum_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_first) |=> (out_sum == ($past(in_a) ^ $past(in_b))));

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_sum && !out_last));

  assert_carry_with_last_R4: assert property (@(posedge clk) disable iff (rst)
    out_carry |-> (out_last && out_valid));

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_reset_clears_R7: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !word_valid));

endmodule

// File: tb/bit_serial_adder_tb_top.sv
module bit_serial_adder_tb_top;

  localparam int N = 8;
  localparam longint MASK = (longint'(1) << N) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_first = 1'b0;
  logic         in_a = 1'b0;
  logic         in_b = 1'b0;
  logic         out_valid, out_sum, out_last, out_carry;
  logic         word_valid, word_carry;
  logic [N-1:0] word_sum;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference model state
  longint ma = 0, mb = 0, wsum_next = 0;
  int     pos = 0;
  bit     e_ov = 0, e_os = 0, e_ol = 0, e_oc = 0;
  bit     e_wv = 0, e_wc = 0;
  longint e_ws = 0;
  string  phase = "R7";

  always #5 clk = ~clk;

  bit_serial_adder #(.N(N), .HAS_WORD_OUT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_sum(out_sum),
    .out_last(out_last), .out_carry(out_carry), .word_valid(word_valid),
    .word_sum(word_sum), .word_carry(word_carry)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s [%s] %s actual=%0h expected=%0h at %0t", req, phase, what, act, exp, $time);
    end
  endtask

  task automatic compare_outputs();
    chk("R5", "out_valid", out_valid, e_ov);
    chk("R1 R2 R3", "out_sum", out_sum, e_os);
    chk("R4", "out_last", out_last, e_ol);
    chk("R4", "out_carry", out_carry, e_oc);
    chk("R8", "word_valid", word_valid, e_wv);
    if (e_wv) begin
      chk("R8", "word_sum", longint'(word_sum), e_ws);
      chk("R8", "word_carry", word_carry, e_wc);
    end
  endtask

  // one clock: check previous expectations, then drive and predict
  task automatic cyc(input bit r, input bit v, input bit f, input bit a, input bit b);
    longint tot;
    @(negedge clk);
    if (done) return;
    compare_outputs();
    e_wv = e_ov && e_ol;
    if (e_wv) begin
      e_ws = wsum_next & MASK;
      e_wc = e_oc;
    end
    rst = r; in_valid = v; in_first = f; in_a = a; in_b = b;
    if (r) begin
      pos = 0; ma = 0; mb = 0;
      e_ov = 0; e_os = 0; e_ol = 0; e_oc = 0; e_wv = 0;
    end else if (!v) begin
      e_ov = 0; e_os = 0; e_ol = 0; e_oc = 0;
    end else begin
      if (f) begin pos = 0; ma = 0; mb = 0; end
      ma = ma | (longint'(a) << pos);
      mb = mb | (longint'(b) << pos);
      tot = ma + mb;
      e_ov = 1;
      e_os = bit'((tot >> pos) & 1);
      e_ol = (pos == N - 1);
      e_oc = e_ol ? bit'((tot >> N) & 1) : 1'b0;
      if (e_ol) begin
        wsum_next = tot;
        pos = 0; ma = 0; mb = 0;
      end else begin
        pos = pos + 1;
      end
    end
  endtask

  task automatic send_word(input longint a, input longint b, input int gap_pct);
    for (int i = 0; i < N; i++) begin
      while (gap_pct > 0 && ($urandom % 100) < gap_pct)
        cyc(0, 0, 0, $urandom % 2, $urandom % 2);
      cyc(0, 1, (i == 0), bit'((a >> i) & 1), bit'((b >> i) & 1));
    end
  endtask

  initial begin
    // reset state
    phase = "R7";
    repeat (3) cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    // directed corner words, back to back (R6)
    phase = "R6";
    send_word(0, 0, 0);
    send_word(MASK, 1, 0);
    send_word(MASK, MASK, 0);
    send_word('h55, 'hAA, 0);
    send_word(1, 1, 0);
    cyc(0, 0, 0, 0, 0);
    // random back-to-back stream
    for (int w = 0; w < 60; w++) send_word($urandom & MASK, $urandom & MASK, 0);
    // idle gaps inside words (R9)
    phase = "R9";
    for (int w = 0; w < 30; w++) send_word($urandom & MASK, $urandom & MASK, 40);
    // mid-word restart with the first marker (R2)
    phase = "R2";
    for (int i = 0; i < 4; i++) cyc(0, 1, (i == 0), 1, 1);
    send_word(MASK, MASK, 0);
    send_word('h0F, 'hF1, 0);
    // reset mid-word with carry pending, then unmarked bits (R7)
    phase = "R7";
    for (int i = 0; i < 3; i++) cyc(0, 1, (i == 0), 1, 1);
    cyc(1, 0, 0, 0, 0);
    for (int i = 0; i < N; i++) cyc(0, 1, 0, 0, (i == 0));
    send_word('h80, 'h80, 0);
    repeat (3) cyc(0, 0, 0, 0, 0);
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule